// File: doc/BRIEF.md
# Lock-Qualified Processor Reset Generator

This block produces a processor reset from two conditions: a phase-lock status input from the clock generator, and an external active-low reset request. Reset is held while the request is asserted or while lock is missing. Once both conditions are good, the block counts a fixed number of system-rate clock cycles (1024 by default) before it releases reset. The same output therefore also tells the board whether the clock has locked.

The output is modelled as an open-drain pin. `rst_od_n_o` low means the pin is actively pulled low. High means the pin is released, and a modelled pull-up then makes `rst_pin_o` read high. The request input is asynchronous and passes through a two-flop synchronizer. The lock input is synchronous to `clk`.

If lock is lost during the settle count, the count clears and the wait starts again. If lock is lost after release, the pin is pulled low once more, because the pin doubles as a lock indicator. A status flag reads high only while the pin is released.

Top module: `rgen_lock_reset`

## Requirements
- R1: While `rst` is high, on the next edge the pin is driven low (`rst_od_n_o`=0, `rst_pin_o`=0, `rst_done_o`=0) and the settle count is zero.
- R2: With the synchronized request high and `lock_i` low, the pin stays driven low indefinitely.
- R3: With the request high, the pin is released on the 1024th consecutive rising edge at which `lock_i` is sampled high. It is still driven low after the 1023rd such edge.
- R4: If `lock_i` is sampled low at any edge before release, including the edge that would complete the count, the count clears. A full new run of 1024 lock-high edges is then needed.
- R5: `rst_req_n_i` low forces the pin low on the third rising edge after it falls (two synchronizer stages plus one control register), whatever the state of lock.
- R6: After `rst_req_n_i` returns high with lock held, the pin stays low for 1025 edges and is released on the 1026th.
- R7: If `rst_req_n_i` is low when `rst` is deasserted, the pin remains low for as long as the request stays low, even with lock high.
- R8: The pin is open-drain. `rst_pin_o` reads 1 only when `rst_od_n_o` is 1 (released), and `rst_done_o` is high exactly when the pin is released.
- R9: The settle counter saturates at 1024. Once released, the pin stays released while request and lock stay high.
- R10: Lock sampled low while released drives the pin low again on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lock_i | input | 1 | Phase-lock status, synchronous to clk |
| rst_req_n_i | input | 1 | Asynchronous active-low reset request |
| rst_od_n_o | output | 1 | Open-drain drive control: 0 pulls the pin low, 1 releases it |
| rst_pin_o | output | 1 | Pin level as read through the modelled pull-up |
| rst_done_o | output | 1 | Status flag: high only while the pin is released |

## Verification
The count reaching its final value and the loss of lock can land on the same clock edge. The bench provokes this by holding lock high for 1023 edges and then dropping it just before the 1024th. Clearing the count must win, so the pin must stay low, and a full new count must follow before release.

A second collision is a request that arrives while the pin is already released and lock is steady. The bench checks that the release holds through the two synchronizer cycles and that the pin falls on exactly the third edge.

// File: rtl/rgen_pkg.sv
package rgen_pkg;

    // Control state of the reset generator
    typedef enum logic [1:0] {
        ST_HELD      = 2'd0,  // external request asserted
        ST_WAIT_LOCK = 2'd1,  // request clear, clock not locked
        ST_SETTLE    = 2'd2,  // locked, counting settle cycles
        ST_RUN       = 2'd3   // pin released
    } rg_state_e;

    // Commands from the controller to the settle counter
    typedef struct packed {
        logic clr;
        logic inc;
    } rg_cnt_cmd_t;

    localparam rg_cnt_cmd_t CMD_IDLE  = '{clr: 1'b0, inc: 1'b0};
    localparam rg_cnt_cmd_t CMD_CLEAR = '{clr: 1'b1, inc: 1'b0};
    localparam rg_cnt_cmd_t CMD_STEP  = '{clr: 1'b0, inc: 1'b1};

    function automatic logic pin_released(rg_state_e st);
        return (st == ST_RUN);
    endfunction

endpackage

// File: rtl/rgen_req_sync.sv
module rgen_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Flops reset to 0 so the request counts as asserted until sampled
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rgen_settle_cnt.sv
module rgen_settle_cnt
    import rgen_pkg::*;
#(
    parameter int LIMIT = 1024,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  rg_cnt_cmd_t      cmd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] PREV = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full = (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clr)           cnt_q <= '0;
        else if (cmd_i.inc && !full)    cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == PREV);

    // R1: reset leaves the counter at zero
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    // R9: the counter never passes its limit
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);

    // R9: a full counter stays full unless cleared
    assert_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (full && !cmd_i.clr) |=> (cnt_q == TOP));

    // R4: a clear command empties the counter
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_i.clr |=> (cnt_q == '0));
endmodule

// File: rtl/rgen_ctrl.sv
module rgen_ctrl
    import rgen_pkg::*;
#(
    parameter int LIMIT = 1024,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_ok_i,   // synchronized request, 1 = no request
    input  logic             lock_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             last_i,
    output rg_cnt_cmd_t      cmd_o,
    output logic             release_o
);
    rg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        cmd_o   = CMD_IDLE;
        if (!req_ok_i) begin
            state_d = ST_HELD;
            cmd_o   = CMD_CLEAR;
        end else if (!lock_i) begin
            state_d = ST_WAIT_LOCK;
            cmd_o   = CMD_CLEAR;
        end else if (state_q == ST_RUN) begin
            state_d = ST_RUN;
        end else begin
            cmd_o   = CMD_STEP;
            state_d = last_i ? ST_RUN : ST_SETTLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT_LOCK;
        else     state_q <= state_d;
    end

    assign release_o = pin_released(state_q);

    // R1: reset holds the pin low
    assert_reset_drives_low_R1: assert property (@(posedge clk)
        rst |=> !release_o);

    // R2: no lock means no release on the next edge
    assert_unlocked_held_R2: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> !release_o);

    // R5: a synchronized request forces the held state
    assert_request_forces_R5: assert property (@(posedge clk) disable iff (rst)
        !req_ok_i |=> (state_q == ST_HELD));

    // R3: release only follows a count that has reached LIMIT-1
    assert_release_after_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> ($past(cnt_i) == CNT_W'(LIMIT - 1)));

    // R10: lock loss while released drops the release
    assert_lock_loss_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (release_o && !lock_i) |=> (state_q == ST_WAIT_LOCK));
endmodule

// File: rtl/rgen_lock_reset.sv
module rgen_lock_reset
    import rgen_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1024,
    parameter int SYNC_STAGES   = 2,
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic rst_req_n_i,
    output logic rst_od_n_o,
    output logic rst_pin_o,
    output logic rst_done_o
);
    logic             req_ok;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    rg_cnt_cmd_t      cmd;
    logic             released;

    rgen_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (rst_req_n_i),
        .sync_o  (req_ok)
    );

    rgen_ctrl #(.LIMIT(SETTLE_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_ok_i  (req_ok),
        .lock_i    (lock_i),
        .cnt_i     (cnt),
        .last_i    (cnt_last),
        .cmd_o     (cmd),
        .release_o (released)
    );

    rgen_settle_cnt #(.LIMIT(SETTLE_CYCLES)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .cnt_o  (cnt),
        .last_o (cnt_last)
    );

    // Open-drain model: drive low or float; the pull-up supplies the high level
    assign rst_od_n_o = released;
    assign rst_pin_o  = rst_od_n_o ? 1'b1 : 1'b0;
    assign rst_done_o = released;

    // R8: the pin never reads high while the driver pulls it low
    assert_open_drain_R8: assert property (@(posedge clk) disable iff (rst)
        rst_pin_o |-> (rst_od_n_o && rst_done_o));
endmodule

// File: tb/rgen_lock_reset_bench.sv
module rgen_lock_reset_bench;
    logic clk = 1'b0;
    logic rst;
    logic lock_i;
    logic rst_req_n_i;
    logic rst_od_n_o;
    logic rst_pin_o;
    logic rst_done_o;

    int n_tests = 0;
    int n_fail  = 0;

    localparam int SETTLE = 1024;

    always #2 clk = ~clk;   // 250 MHz

    rgen_lock_reset u_rgen_lock_reset (
        .clk         (clk),
        .rst         (rst),
        .lock_i      (lock_i),
        .rst_req_n_i (rst_req_n_i),
        .rst_od_n_o  (rst_od_n_o),
        .rst_pin_o   (rst_pin_o),
        .rst_done_o  (rst_done_o)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected release level checked on all three outputs
    task automatic check_rel(input string tag, input logic exp);
        n_tests++;
        if (rst_od_n_o !== exp || rst_pin_o !== exp || rst_done_o !== exp) begin
            n_fail++;
            $display("FAIL %s: od_n=%b pin=%b done=%b expected %b",
                     tag, rst_od_n_o, rst_pin_o, rst_done_o, exp);
        end
    endtask

    task automatic do_reset(input logic req_n);
        rst = 1'b1; lock_i = 1'b0; rst_req_n_i = req_n;
        edges(4);
        check_rel("R1 reset drives pin low", 1'b0);
        rst = 1'b0;
        edges(4);
    endtask

    task automatic t_no_lock();
        edges(200);
        check_rel("R2 unlocked stays low", 1'b0);
    endtask

    task automatic t_lock_release();
        lock_i = 1'b1;
        edges(SETTLE - 1);
        check_rel("R3 low after 1023 lock edges", 1'b0);
        edges(1);
        check_rel("R3 released on 1024th edge", 1'b1);
        check_rel("R8 pin and status follow release", 1'b1);
        edges(300);
        check_rel("R9 stays released after saturation", 1'b1);
    endtask

    task automatic t_lock_loss_released();
        lock_i = 1'b0;
        edges(1);
        check_rel("R10 lock loss pulls pin low", 1'b0);
    endtask

    task automatic t_lock_loss_midcount();
        lock_i = 1'b1;
        edges(500);
        lock_i = 1'b0;
        edges(1);
        lock_i = 1'b1;
        edges(600);
        check_rel("R4 midcount loss restarts wait", 1'b0);
        edges(SETTLE - 1 - 600);
        check_rel("R4 low after 1023 new edges", 1'b0);
        edges(1);
        check_rel("R4 released after fresh 1024", 1'b1);
    endtask

    task automatic t_loss_on_last_edge();
        lock_i = 1'b0;
        edges(2);
        lock_i = 1'b1;
        edges(SETTLE - 1);
        lock_i = 1'b0;      // sampled low at the would-be completing edge
        edges(1);
        check_rel("R4 loss on final edge blocks release", 1'b0);
        lock_i = 1'b1;
        edges(SETTLE - 1);
        check_rel("R4 recount not yet done", 1'b0);
        edges(1);
        check_rel("R4 recount releases", 1'b1);
    endtask

    task automatic t_request();
        rst_req_n_i = 1'b0;
        edges(2);
        check_rel("R5 still released during sync", 1'b1);
        edges(1);
        check_rel("R5 request forces low on third edge", 1'b0);
        edges(300);
        check_rel("R5 held low with lock high", 1'b0);
        rst_req_n_i = 1'b1;
        edges(SETTLE + 1);
        check_rel("R6 low 1025 edges after request ends", 1'b0);
        edges(1);
        check_rel("R6 released on 1026th edge", 1'b1);
    endtask

    task automatic t_powerup_req_low();
        do_reset(1'b0);
        lock_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            edges(500);
            check_rel("R7 request low at power-up holds pin", 1'b0);
        end
        rst_req_n_i = 1'b1;
        edges(SETTLE + 1);
        check_rel("R7 low until count after request ends", 1'b0);
        edges(1);
        check_rel("R7 released after request and count", 1'b1);
    endtask

    initial begin
        do_reset(1'b1);
        t_no_lock();
        t_lock_release();
        t_lock_loss_released();
        t_lock_loss_midcount();
        t_loss_on_last_edge();
        t_request();
        t_powerup_req_low();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule